// File: doc/BRIEF.md
# Lane-Partitioned Operand Network Router

This block delivers a producer instruction's result into the operand buffer of its consumer instruction. The core's issue window has four lanes of 32 slots each, 128 slots in total. Every slot has a left and a right 64-bit operand entry. Each result arrives with the producer's slot index, the target slot index and an operand select. When the route is legal, the router issues one registered write to the operand store.

An execution mode is latched once for each instruction block from a header bit. In vector mode, operands must stay inside the producer's lane. A write that crosses lanes is dropped and flagged. In scalar mode, any slot may feed any other slot. The ALUs of the upper two lanes are switched off in scalar mode, but their window and operand storage stay addressable through the same slot indices. The router also drives the per-lane ALU enables from the mode.

Top module: `opnet_router`

## Requirements
- R1: After reset, buf_we and illegal are 0, mode_vec is 0 (scalar) and alu_en is 4'b0011.
- R2: A blk_start pulse while no block is active makes mode_vec equal hdr_vec (1 = vector, 0 = scalar) from the next cycle, and the block becomes active.
- R3: The lane of a slot is bits [6:5] of its 7-bit index. In vector mode, a valid result whose target lane differs from its producer lane gives buf_we = 0 and illegal = 1 in the next cycle only.
- R4: A legal valid result gives, in the next cycle, buf_we = 1, buf_addr = {res_dst, res_opsel} (bit 0 is the operand select, 0 = left, 1 = right) and buf_data = res_data.
- R5: In scalar mode, every target is legal, including slots in lanes 2 and 3, and the address is not remapped.
- R6: alu_en is 4'b1111 in vector mode and 4'b0011 in scalar mode.
- R7: A blk_start while a block is active is ignored, and mode_vec keeps its value. blk_end ends the block. When blk_end and blk_start arrive together while a block is active, the start is ignored.
- R8: A result that arrives in the same cycle as an accepted blk_start is checked against the mode that was in force before that strobe.
- R9: Without res_valid, buf_we and illegal are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| blk_start | input | 1 | Block start and mode-load strobe |
| hdr_vec | input | 1 | Header mode bit, 1 = vector |
| blk_end | input | 1 | Block boundary, ends the active block |
| res_valid | input | 1 | Producer result valid |
| res_src | input | 7 | Producer slot index |
| res_dst | input | 7 | Target slot index |
| res_opsel | input | 1 | Operand select, 0 = left, 1 = right |
| res_data | input | 64 | Result value |
| buf_we | output | 1 | Operand buffer write enable |
| buf_addr | output | 8 | Buffer address {slot, operand} |
| buf_data | output | 64 | Write data |
| illegal | output | 1 | One-cycle flag for a rejected cross-lane target |
| mode_vec | output | 1 | Current block mode, 1 = vector |
| alu_en | output | 4 | Per-lane ALU enables |

## Verification
The hardest cases to reach are the ones where block timing overlaps: a mode strobe during an active block, a strobe that coincides with blk_end, and a result that arrives in the same cycle as an accepted strobe that changes the mode. Random traffic seldom lines these up. Directed sequences set them up explicitly, and seeded random stimulus then mixes strobes, block ends and results, with half of all targets biased into the producer's lane so that both legal and cross-lane vector routes occur often.

// File: rtl/opnet_router.sv
module opnet_router #(
  parameter int LANES      = 4,
  parameter int LANE_SLOTS = 32,
  parameter int DATA_W     = 64,
  localparam int SLOT_W    = $clog2(LANES * LANE_SLOTS),
  localparam int LANE_W    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_start,
  input  logic              hdr_vec,
  input  logic              blk_end,
  input  logic              res_valid,
  input  logic [SLOT_W-1:0] res_src,
  input  logic [SLOT_W-1:0] res_dst,
  input  logic              res_opsel,
  input  logic [DATA_W-1:0] res_data,
  output logic              buf_we,
  output logic [SLOT_W:0]   buf_addr,
  output logic [DATA_W-1:0] buf_data,
  output logic              illegal,
  output logic              mode_vec,
  output logic [LANES-1:0]  alu_en
);

  logic blk_active;
  logic cross_lane;

  assign cross_lane = mode_vec &&
    (res_src[SLOT_W-1 -: LANE_W] != res_dst[SLOT_W-1 -: LANE_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_active <= 1'b0;
      mode_vec   <= 1'b0;
    end else if (blk_start && !blk_active) begin
      blk_active <= 1'b1;
      mode_vec   <= hdr_vec;
    end else if (blk_end) begin
      blk_active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_we  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      buf_we  <= res_valid && !cross_lane;
      illegal <= res_valid && cross_lane;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr <= '0;
      buf_data <= '0;
    end else if (res_valid && !cross_lane) begin
      buf_addr <= {res_dst, res_opsel};
      buf_data <= res_data;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_alu
    if (i < LANES / 2) begin : g_low
      assign alu_en[i] = 1'b1;
    end else begin : g_high
      assign alu_en[i] = mode_vec;
    end
  end

endmodule

module opnet_router_chk #(
  parameter int SLOT_W = 7,
  parameter int LANE_W = 2,
  parameter int LANES  = 4,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_active,
  input logic              blk_start,
  input logic              hdr_vec,
  input logic              res_valid,
  input logic [SLOT_W-1:0] res_src,
  input logic [SLOT_W-1:0] res_dst,
  input logic              res_opsel,
  input logic [DATA_W-1:0] res_data,
  input logic              buf_we,
  input logic [SLOT_W:0]   buf_addr,
  input logic [DATA_W-1:0] buf_data,
  input logic              illegal,
  input logic              mode_vec,
  input logic [LANES-1:0]  alu_en
);

  logic xl;
  assign xl = res_src[SLOT_W-1 -: LANE_W] != res_dst[SLOT_W-1 -: LANE_W];

  assert_cross_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_vec && xl) |=> (illegal && !buf_we));

  assert_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !(mode_vec && xl)) |=>
      (buf_we && buf_addr == $past({res_dst, res_opsel}) && buf_data == $past(res_data)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (!buf_we && !illegal));

  assert_scalar_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_vec |-> (alu_en[LANES-1:LANES/2] == '0));

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_active |=> $stable(mode_vec));

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !blk_active) |=> (mode_vec == $past(hdr_vec) && blk_active));

  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_we && illegal));

endmodule

bind opnet_router opnet_router_chk #(
  .SLOT_W(SLOT_W), .LANE_W(LANE_W), .LANES(LANES), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_opnet_router.sv
module sim_opnet_router;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_start = 1'b0, hdr_vec = 1'b0, blk_end = 1'b0, res_valid = 1'b0, res_opsel = 1'b0;
  logic [6:0] res_src = '0, res_dst = '0;
  logic [63:0] res_data = '0;
  logic buf_we, illegal, mode_vec;
  logic [7:0] buf_addr;
  logic [63:0] buf_data;
  logic [3:0] alu_en;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_mode = 0, m_active = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnet_router u0 (.*);

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_cross(bit mode, logic [6:0] s, logic [6:0] d);
    return mode && (s[6:5] != d[6:5]);
  endfunction

  task automatic step(bit bs, bit hv, bit be, bit v, logic [6:0] s, logic [6:0] d,
                      bit op, logic [63:0] dat, string tag);
    bit xc, ewe, eill;
    blk_start = bs; hdr_vec = hv; blk_end = be;
    res_valid = v; res_src = s; res_dst = d; res_opsel = op; res_data = dat;
    xc = is_cross(m_mode, s, d);
    ewe = v && !xc;
    eill = v && xc;
    if (bs && !m_active) begin m_active = 1; m_mode = hv; end
    else if (be) m_active = 0;
    @(negedge clk);
    check({tag, " we"}, buf_we, ewe);
    check({tag, " illegal"}, illegal, eill);
    check({tag, " mode"}, mode_vec, m_mode);
    check({tag, " alu_en R6"}, alu_en, m_mode ? 4'hF : 4'h3);
    if (ewe) begin
      check({tag, " addr"}, buf_addr, {d, op});
      check({tag, " data"}, buf_data, dat);
    end
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed1234;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    check("R1 we", buf_we, 0);
    check("R1 illegal", illegal, 0);
    check("R1 mode", mode_vec, 0);
    check("R1 alu_en", alu_en, 4'h3);
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 0, 0, 0, 0, 0, 0, 0, "R2 load scalar");
    step(0, 0, 0, 1, 7'd3, 7'd100, 1, 64'hDEAD_BEEF_0000_0001, "R5 scalar lane0->lane3");
    step(0, 0, 0, 1, 7'd127, 7'd64, 0, 64'h1234, "R5 scalar lane3->lane2");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R7 strobe while active");
    step(0, 0, 1, 0, 0, 0, 0, 0, "R7 end");
    step(1, 1, 0, 1, 7'd1, 7'd127, 0, 64'h55, "R8 operand with vector strobe");
    step(0, 0, 0, 1, 7'd1, 7'd127, 0, 64'h66, "R3 vector cross");
    idle("R3 pulse ends");
    step(0, 0, 0, 1, 7'd40, 7'd63, 1, 64'hABCD, "R4 vector same lane");
    step(0, 0, 0, 0, 7'd40, 7'd0, 1, 64'h1, "R9 no valid");
    step(1, 0, 1, 0, 0, 0, 0, 0, "R7 end+start while active");
    step(1, 0, 0, 1, 7'd96, 7'd10, 1, 64'h77, "R8 old vector mode judged");
    step(0, 0, 0, 1, 7'd96, 7'd10, 1, 64'h88, "R5 now scalar");

    for (int i = 0; i < 3000; i++) begin
      logic [6:0] s, d;
      bit bs, be, v;
      s = 7'($urandom);
      d = ($urandom % 2) ? {s[6:5], 5'($urandom)} : 7'($urandom);
      bs = ($urandom % 16) == 0;
      be = ($urandom % 16) == 0;
      v = ($urandom % 4) != 0;
      step(bs, 1'($urandom), be, v, s, d, 1'($urandom), {$urandom, $urandom},
           "R3 R4 R7 R8 R9 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule